// File: doc/BRIEF.md
# Silicon Strip Cluster Finder

This block turns a stream of raw silicon-strip hits into clusters. Each incoming hit carries a strip number, a raw amplitude, a flag that says whether the strip is axial or stereo, and a marker for the last hit of an event. The block first looks up three per-strip calibration values: a bad-strip flag, a baseline to subtract and a gain factor. It uses them to correct the amplitude. Corrected hits that survive the threshold and sit on consecutive strips of the same layer type are then merged into clusters.

For every closed cluster the block emits one record. The record holds the charge-weighted position in quarter-strip units, the summed corrected charge, the width in strips and the strip-type flag. The position is computed by a small iterative divider. While that divider is working, the input is held off through the ready signal.

The calibration tables are filled through a write port that sets all three values of one strip in a single cycle.

Top module: `scf_cluster_finder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and every table entry reads as mask 0, baseline 0 and gain 64 (unity).
- R2: A hit on a strip whose table mask bit is 1 is discarded. It joins no cluster, and its place counts as a gap between its neighbours.
- R3: The corrected amplitude is floor((amp − baseline) × gain / 64), with gain an unsigned value that has 6 fractional bits. The charge of a cluster is the sum of the corrected amplitudes of its hits.
- R4: A hit whose raw amplitude is at or below its baseline, or whose corrected amplitude is at or below `cfg_thresh`, is treated as no hit.
- R5: Hits on consecutive strip numbers of the same type form one cluster. A hit that skips one or more strips closes the open cluster and starts a new one.
- R6: A change of `in_stereo` (0 = axial, 1 = stereo) closes the open cluster. `out_stereo` repeats the type of the cluster's hits.
- R7: A beat with `in_last` = 1 closes every cluster still open once that beat's own hit has been taken into account.
- R8: A cluster holds at most 8 strips. A ninth adjacent hit closes it and starts a new cluster.
- R9: `out_centroid` = 4 × first strip + floor(4 × Σ charge_i × (strip_i − first strip) / Σ charge_i). It is unsigned, with 2 fractional bits.
- R10: `out_width` gives the number of hits merged into the cluster.
- R11: While a centroid division is in progress and a hit is already waiting, `in_ready` is 0. No accepted hit is ever lost.
- R12: Records leave in the order their clusters close, each as a one-cycle `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Hit beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_strip | input | 8 | Strip number |
| in_amp | input | 8 | Raw amplitude |
| in_stereo | input | 1 | Strip type, 1 = stereo |
| in_last | input | 1 | Final beat of the event |
| cfg_thresh | input | 10 | Corrected-amplitude threshold |
| tbl_we | input | 1 | Calibration write strobe |
| tbl_stereo | input | 1 | Strip type of the entry written |
| tbl_strip | input | 8 | Strip number of the entry written |
| tbl_mask | input | 1 | Bad-strip flag to store |
| tbl_ped | input | 8 | Baseline to store |
| tbl_gain | input | 8 | Gain to store (6 fractional bits) |
| out_valid | output | 1 | Cluster record pulse |
| out_centroid | output | 10 | Weighted position, quarter strips |
| out_charge | output | 13 | Summed corrected charge |
| out_width | output | 4 | Number of strips in cluster |
| out_stereo | output | 1 | Strip type of cluster |

## Verification
Directed runs apply one distinguishing pattern each:
- a masked strip in the middle of a run, which must split it in two;
- a sub-threshold strip, which must split a run the same way;
- a type flip between adjacent strip numbers, which must not merge;
- an end-of-event marker between adjacent strips;
- ten adjacent strips, which must split as 8 and 2;
- a non-adjacent hit that is also the last one, which must give two records from a single beat.

Random events with randomised tables, thresholds, gaps and type changes then compare every record field against a bench model. This separates weighting errors from grouping errors, and the back-to-back hits make sure the ready stall occurs without losing a hit.

// File: rtl/scf_pkg.sv
package scf_pkg;
    localparam int STRIP_W    = 8;
    localparam int AMP_W      = 8;
    localparam int GAIN_W     = 8;
    localparam int GAIN_FRAC  = 6;
    localparam int MAX_STRIPS = 8;
    localparam int FRAC_BITS  = 2;

    localparam int CORR_W    = AMP_W + GAIN_W - GAIN_FRAC;
    localparam int OFF_W     = $clog2(MAX_STRIPS);
    localparam int WID_W     = $clog2(MAX_STRIPS + 1);
    localparam int CHG_W     = CORR_W + OFF_W;
    localparam int WSUM_W    = CHG_W + OFF_W;
    localparam int NUM_W     = WSUM_W + FRAC_BITS;
    localparam int QUO_W     = OFF_W + FRAC_BITS;
    localparam int CEN_W     = STRIP_W + FRAC_BITS;
    localparam int TBL_AW    = STRIP_W + 1;
    localparam int TBL_DEPTH = 1 << TBL_AW;

    typedef struct packed {
        logic                mask;
        logic [AMP_W-1:0]    ped;
        logic [GAIN_W-1:0]   gain;
    } scf_cal_t;

    typedef struct packed {
        logic [STRIP_W-1:0]  strip;
        logic                stereo;
        logic                hit;
        logic [CORR_W-1:0]   amp;
        logic                last;
    } scf_hit_t;

    typedef struct packed {
        logic [STRIP_W-1:0]  start;
        logic                stereo;
        logic [WID_W-1:0]    width;
        logic [CHG_W-1:0]    charge;
        logic [WSUM_W-1:0]   wsum;
    } scf_clus_t;

    function automatic scf_cal_t scf_cal_default();
        scf_cal_t c;
        c.mask = 1'b0;
        c.ped  = '0;
        c.gain = GAIN_W'(1 << GAIN_FRAC);
        return c;
    endfunction

    function automatic scf_clus_t scf_clus_seed(scf_hit_t h);
        scf_clus_t c;
        c.start  = h.strip;
        c.stereo = h.stereo;
        c.width  = WID_W'(1);
        c.charge = CHG_W'(h.amp);
        c.wsum   = '0;
        return c;
    endfunction

    function automatic scf_clus_t scf_clus_grow(scf_clus_t c, scf_hit_t h);
        scf_clus_t n;
        n        = c;
        n.width  = c.width + WID_W'(1);
        n.charge = c.charge + CHG_W'(h.amp);
        n.wsum   = c.wsum + WSUM_W'(h.amp) * WSUM_W'(c.width);
        return n;
    endfunction
endpackage

// File: rtl/scf_correct.sv
module scf_correct
    import scf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [TBL_AW-1:0]   wr_addr,
    input  scf_cal_t            wr_cal,
    input  logic [TBL_AW-1:0]   rd_addr,
    input  logic [AMP_W-1:0]    raw_amp,
    input  logic [CORR_W-1:0]   thresh,
    output logic                hit,
    output logic [CORR_W-1:0]   corr
);
    scf_cal_t table_q [TBL_DEPTH];
    scf_cal_t cal;
    logic [AMP_W:0]           diff;
    logic                     above_base;
    logic [AMP_W+GAIN_W-1:0]  prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) table_q[i] <= scf_cal_default();
        end else if (wr_en) begin
            table_q[wr_addr] <= wr_cal;
        end
    end

    always_comb begin
        cal        = table_q[rd_addr];
        diff       = {1'b0, raw_amp} - {1'b0, cal.ped};
        above_base = !diff[AMP_W] && (diff[AMP_W-1:0] != '0);
        prod       = (AMP_W+GAIN_W)'(diff[AMP_W-1:0]) * (AMP_W+GAIN_W)'(cal.gain);
        corr       = above_base ? prod[AMP_W+GAIN_W-1:GAIN_FRAC] : '0;
        hit        = !cal.mask && above_base && (corr > thresh);
    end
endmodule

// File: rtl/scf_merge.sv
module scf_merge
    import scf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  scf_hit_t   hit_i,
    output logic       close,
    output scf_clus_t  clus_o,
    output logic       defer
);
    logic               open_q;
    scf_clus_t          cur_q;
    logic [STRIP_W-1:0] tail_q;

    logic      adjacent, extend, fresh, close_old, close_next;
    scf_clus_t next_c;

    always_comb begin
        adjacent   = open_q
                     && (hit_i.stereo == cur_q.stereo)
                     && ({1'b0, hit_i.strip} == {1'b0, tail_q} + (STRIP_W+1)'(1))
                     && (cur_q.width < WID_W'(MAX_STRIPS));
        extend     = hit_i.hit && adjacent;
        fresh      = hit_i.hit && !adjacent;
        next_c     = extend ? scf_clus_grow(cur_q, hit_i)
                   : fresh  ? scf_clus_seed(hit_i)
                   : cur_q;
        close_old  = fresh && open_q;
        close_next = hit_i.last && !close_old && (open_q || fresh);
        defer      = close_old && hit_i.last;
        close      = step && (close_old || close_next);
        clus_o     = close_old ? cur_q : next_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cur_q  <= '0;
            tail_q <= '0;
        end else if (step) begin
            if (close_old) begin
                open_q <= 1'b1;
                cur_q  <= next_c;
                tail_q <= hit_i.strip;
            end else if (close_next) begin
                open_q <= 1'b0;
            end else if (hit_i.hit) begin
                open_q <= 1'b1;
                cur_q  <= next_c;
                tail_q <= hit_i.strip;
            end
        end
    end
endmodule

// File: rtl/scf_divider.sv
module scf_divider #(
    parameter int NUM_W = 18,
    parameter int DEN_W = 13,
    parameter int QUO_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [QUO_W-1:0] quo
);
    localparam int CNT_W = (QUO_W > 1) ? $clog2(QUO_W) : 1;

    logic [NUM_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NUM_W-1:0] trial;

    assign trial = NUM_W'(den_q) << cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            quo   <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= num;
                den_q <= den;
                quo   <= '0;
                cnt_q <= CNT_W'(QUO_W - 1);
                busy  <= 1'b1;
            end else if (busy) begin
                if (rem_q >= trial) begin
                    rem_q      <= rem_q - trial;
                    quo[cnt_q] <= 1'b1;
                end
                if (cnt_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/scf_cluster_finder.sv
module scf_cluster_finder
    import scf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [STRIP_W-1:0]  in_strip,
    input  logic [AMP_W-1:0]    in_amp,
    input  logic                in_stereo,
    input  logic                in_last,
    input  logic [CORR_W-1:0]   cfg_thresh,
    input  logic                tbl_we,
    input  logic                tbl_stereo,
    input  logic [STRIP_W-1:0]  tbl_strip,
    input  logic                tbl_mask,
    input  logic [AMP_W-1:0]    tbl_ped,
    input  logic [GAIN_W-1:0]   tbl_gain,
    output logic                out_valid,
    output logic [CEN_W-1:0]    out_centroid,
    output logic [CHG_W-1:0]    out_charge,
    output logic [WID_W-1:0]    out_width,
    output logic                out_stereo
);
    scf_cal_t          wr_cal;
    logic              c_hit;
    logic [CORR_W-1:0] c_corr;
    logic              s1_valid;
    scf_hit_t          s1;
    logic              step, consume, accept, defer, div_start;
    scf_clus_t         closed, hold_q;
    logic              div_busy, div_done;
    logic [QUO_W-1:0]  div_quo;

    assign wr_cal = '{mask: tbl_mask, ped: tbl_ped, gain: tbl_gain};

    scf_correct u_corr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_addr ({tbl_stereo, tbl_strip}),
        .wr_cal  (wr_cal),
        .rd_addr ({in_stereo, in_strip}),
        .raw_amp (in_amp),
        .thresh  (cfg_thresh),
        .hit     (c_hit),
        .corr    (c_corr)
    );

    assign step     = s1_valid && !div_busy;
    assign consume  = step && !defer;
    assign in_ready = !s1_valid || consume;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1       <= '0;
        end else if (accept) begin
            s1_valid  <= 1'b1;
            s1.strip  <= in_strip;
            s1.stereo <= in_stereo;
            s1.hit    <= c_hit;
            s1.amp    <= c_corr;
            s1.last   <= in_last;
        end else if (consume) begin
            s1_valid <= 1'b0;
        end else if (step && defer) begin
            s1.hit <= 1'b0;
        end
    end

    scf_merge u_merge (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .hit_i  (s1),
        .close  (div_start),
        .clus_o (closed),
        .defer  (defer)
    );

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else if (div_start) hold_q <= closed;
    end

    scf_divider #(
        .NUM_W (NUM_W),
        .DEN_W (CHG_W),
        .QUO_W (QUO_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   ({closed.wsum, {FRAC_BITS{1'b0}}}),
        .den   (closed.charge),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_centroid <= '0;
            out_charge   <= '0;
            out_width    <= '0;
            out_stereo   <= 1'b0;
        end else begin
            out_valid <= div_done;
            if (div_done) begin
                out_centroid <= {hold_q.start, {FRAC_BITS{1'b0}}} + CEN_W'(div_quo);
                out_charge   <= hold_q.charge;
                out_width    <= hold_q.width;
                out_stereo   <= hold_q.stereo;
            end
        end
    end
endmodule

// File: rtl/scf_checker.sv
module scf_checker
    import scf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             s1_valid,
    input logic             div_busy,
    input logic             div_start,
    input logic             out_valid,
    input logic [CHG_W-1:0] out_charge,
    input logic [WID_W-1:0] out_width
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_stall_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (div_busy && s1_valid) |-> !in_ready);

    assert_start_idle_R11: assert property (@(posedge clk) disable iff (rst)
        div_start |-> !div_busy);

    assert_pulse_single_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_width_cap_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_width != '0) && (out_width <= WID_W'(MAX_STRIPS)));

    assert_charge_floor_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_charge >= CHG_W'(out_width)));
endmodule

bind scf_cluster_finder scf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .s1_valid   (s1_valid),
    .div_busy   (div_busy),
    .div_start  (div_start),
    .out_valid  (out_valid),
    .out_charge (out_charge),
    .out_width  (out_width)
);

// File: tb/scf_cluster_finder_tb.sv
module scf_cluster_finder_tb;
    import scf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic in_valid = 0, in_ready, in_stereo = 0, in_last = 0;
    logic [7:0] in_strip = 0, in_amp = 0;
    logic [CORR_W-1:0] cfg_thresh = 0;
    logic tbl_we = 0, tbl_stereo = 0, tbl_mask = 0;
    logic [7:0] tbl_strip = 0, tbl_ped = 0, tbl_gain = 0;
    logic out_valid, out_stereo;
    logic [CEN_W-1:0] out_centroid;
    logic [CHG_W-1:0] out_charge;
    logic [WID_W-1:0] out_width;

    scf_cluster_finder u_dut (.*);

    typedef struct { int cen; int chg; int wid; int st; } rec_t;
    rec_t exp_q[$];
    rec_t got_q[$];

    int n_checks = 0, n_fail = 0;
    bit saw_stall = 0;
    bit b_mask[512];
    int b_ped[512];
    int b_gain[512];
    int b_thresh = 0;
    bit m_open = 0;
    int m_start, m_tail, m_st, m_wid, m_chg, m_wsum;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (out_valid) got_q.push_back('{int'(out_centroid), int'(out_charge), int'(out_width), int'(out_stereo)});
        if (in_valid && !in_ready) saw_stall = 1;
    end

    function automatic void model_close();
        exp_q.push_back('{m_start * 4 + (m_wsum * 4) / m_chg, m_chg, m_wid, m_st});
        m_open = 0;
    endfunction

    function automatic void model_hit(int strip, int amp, int st, bit last);
        int idx = st * 256 + strip;
        int d = amp - b_ped[idx];
        int corr = (d > 0) ? (d * b_gain[idx]) >> 6 : 0;
        bit hit = !b_mask[idx] && d > 0 && corr > b_thresh;
        if (hit) begin
            if (m_open && st == m_st && strip == m_tail + 1 && m_wid < 8) begin
                m_wsum += corr * m_wid; m_wid++; m_chg += corr; m_tail = strip;
            end else begin
                if (m_open) model_close();
                m_open = 1; m_start = strip; m_tail = strip; m_st = st;
                m_wid = 1; m_chg = corr; m_wsum = 0;
            end
        end
        if (last && m_open) model_close();
    endfunction

    task automatic send(input int strip, input int amp, input int st, input bit last);
        @(negedge clk);
        in_valid = 1; in_strip = 8'(strip); in_amp = 8'(amp); in_stereo = st[0]; in_last = last;
        while (!in_ready) @(negedge clk);
        model_hit(strip, amp, st, last);
        @(negedge clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic wr_tbl(input int st, input int strip, input bit mask, input int ped, input int gain);
        @(negedge clk);
        tbl_we = 1; tbl_stereo = st[0]; tbl_strip = 8'(strip);
        tbl_mask = mask; tbl_ped = 8'(ped); tbl_gain = 8'(gain);
        b_mask[st*256+strip] = mask; b_ped[st*256+strip] = ped; b_gain[st*256+strip] = gain;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic set_thresh(input int t);
        @(negedge clk);
        cfg_thresh = CORR_W'(t); b_thresh = t;
    endtask

    task automatic drain_compare(input string req);
        repeat (40) @(negedge clk);
        check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            check(got_q[i].cen == exp_q[i].cen, "R9 centroid", got_q[i].cen, exp_q[i].cen);
            check(got_q[i].chg == exp_q[i].chg, "R3 charge", got_q[i].chg, exp_q[i].chg);
            check(got_q[i].wid == exp_q[i].wid, "R10 width", got_q[i].wid, exp_q[i].wid);
            check(got_q[i].st == exp_q[i].st, "R6 type", got_q[i].st, exp_q[i].st);
        end
    endtask

    task automatic reset_q();
        got_q.delete(); exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        for (int i = 0; i < 512; i++) begin b_mask[i] = 0; b_ped[i] = 0; b_gain[i] = 64; end
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1, "R1 in_ready", in_ready, 1);

        // R5 / R1 default tables (unity gain): one weighted run plus gap
        send(20, 40, 0, 0); send(21, 80, 0, 0); send(22, 40, 0, 0);
        send(30, 10, 0, 0); send(31, 10, 0, 0); send(32, 10, 0, 1);
        drain_compare("R5 count");
        check(got_q.size() > 0 && got_q[0].cen == 84, "R9 centroid 21.0", got_q.size() > 0 ? got_q[0].cen : -1, 84);
        check(saw_stall == 1, "R11 stall seen", saw_stall, 1);
        reset_q();

        // R2 masked middle strip splits run
        wr_tbl(0, 51, 1, 0, 64);
        send(50, 30, 0, 0); send(51, 30, 0, 0); send(52, 30, 0, 1);
        drain_compare("R2 count");
        check(got_q.size() == 2, "R2 split", got_q.size(), 2);
        reset_q();

        // R3 baseline and gain
        wr_tbl(0, 70, 0, 20, 96);
        send(70, 60, 0, 1);
        drain_compare("R3 count");
        check(got_q.size() > 0 && got_q[0].chg == 60, "R3 corrected", got_q.size() > 0 ? got_q[0].chg : -1, 60);
        reset_q();

        // R4 threshold and below-baseline
        set_thresh(10);
        wr_tbl(0, 62, 0, 50, 64);
        send(60, 30, 0, 0); send(61, 10, 0, 0); send(62, 40, 0, 0); send(63, 30, 0, 1);
        drain_compare("R4 count");
        check(got_q.size() == 2, "R4 split", got_q.size(), 2);
        reset_q();
        set_thresh(0);

        // R6 type change between adjacent numbers
        send(80, 20, 0, 0); send(81, 20, 1, 1);
        drain_compare("R6 count");
        check(got_q.size() == 2 && got_q[1].st == 1, "R6 stereo flag", got_q.size(), 2);
        reset_q();

        // R7 event end between adjacent strips
        send(90, 20, 0, 1); send(91, 20, 0, 1);
        drain_compare("R7 count");
        check(got_q.size() == 2, "R7 split", got_q.size(), 2);
        reset_q();

        // R8 cap at 8 strips
        for (int s = 100; s < 110; s++) send(s, 25 + s % 7, 1, s == 109);
        drain_compare("R8 count");
        check(got_q.size() == 2 && got_q[0].wid == 8 && got_q[1].wid == 2, "R8 widths",
              got_q.size() > 0 ? got_q[0].wid : -1, 8);
        reset_q();

        // R7 / R12 double close from one beat
        send(120, 50, 0, 0); send(121, 50, 0, 0); send(140, 70, 0, 1);
        drain_compare("R12 count");
        check(got_q.size() == 2 && got_q[1].cen == 560, "R12 order", got_q.size() > 1 ? got_q[1].cen : -1, 560);
        reset_q();

        // random events
        for (int i = 0; i < 512; i++) begin
            if ($urandom % 5 == 0)
                wr_tbl(i / 256, i % 256, ($urandom % 20) == 0, $urandom % 30, 32 + $urandom % 96);
        end
        for (int ev = 0; ev < 30; ev++) begin
            int st = $urandom % 2;
            int strip = $urandom % 40;
            int n = 5 + $urandom % 20;
            set_thresh($urandom % 8);
            for (int h = 0; h < n; h++) begin
                send(strip, $urandom % 256, st, h == n - 1);
                if ($urandom % 10 == 0) begin st = 1 - st; strip = $urandom % 40; end
                else strip += ($urandom % 4 == 0) ? 2 + $urandom % 2 : 1;
                if (strip > 255) strip = 255;
            end
        end
        drain_compare("R11 R12 random count");
        reset_q();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule